// File: doc/BRIEF.md
# Overridable GPIO Port

This block is an eight-pin general-purpose I/O port whose pins can be handed to on-chip peripherals one function at a time. Each pin has four override pairs, an enable and a value. They cover the pull-up, the drive direction, the driven level and the digital-input gate. When an enable is low, that function takes its normal value from the port's own registers. Software programs a direction register and an output/pull-up register over a small register bus. The block drives output-enable, output-level and pull-up-enable signals for each pad to a pad wrapper.

Pad inputs pass through a two-stage synchroniser and can then be read back as the pin register. An SPI controller supplies its enable and its master/slave role. From these the port forces the serial-clock pin or the master-input data pin to be an input, as the SPI role requires. The pull-up of a forced pin stays under register control.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction and output registers hold 0, so every `pad_oe` and `pad_pu` bit is 0.
- R2: A bus write (`bus_we`=1) to address 0 loads the direction register and to address 1 loads the output register on the next rising edge. Reads of those addresses on `bus_rdata` return the stored values with no added latency.
- R3: For each pin and each function, a set override enable selects the override value in place of the register-derived value. This holds for `pad_oe` (direction), `pad_out` (level), `pad_pu` (pull-up) and the digital-input gate (1 = input enabled).
- R4: With `spi_en`=1 and `spi_master`=0, the serial-clock pin (bit 7) has `pad_oe`=0, whatever its direction bit and its external direction override.
- R5: With `spi_en`=1 and `spi_master`=1, the serial-clock pin's `pad_oe` equals its direction bit.
- R6: With `spi_en`=1 and `spi_master`=1, the master-input pin (bit 6) has `pad_oe`=0. In slave mode its `pad_oe` equals its direction bit.
- R7: When the SPI role forces a pin to be an input, that pin's `pad_pu` equals its output-register bit (while `pull_dis`=0).
- R8: Without a pull-up override, `pad_pu` is 1 only when the pin is an input and its output bit is 1 and `pull_dis`=0. `pull_dis`=1 clears every non-overridden pull-up.
- R9: A level on `pad_in` appears in the pin register (read at address 2) after exactly two rising edges, and not after one. A pin whose digital input is disabled reads 0.
- R10: Writes to addresses 2 and 3 change no register. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 direction, 1 output, 2 pins, 3 reserved) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pull_dis | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI controller enabled |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| ovr_pu_en | input | 8 | Per-pin pull-up override enable |
| ovr_pu_val | input | 8 | Per-pin pull-up override value |
| ovr_dir_en | input | 8 | Per-pin direction override enable |
| ovr_dir_val | input | 8 | Per-pin direction override value (1 = drive) |
| ovr_out_en | input | 8 | Per-pin output-level override enable |
| ovr_out_val | input | 8 | Per-pin output-level override value |
| ovr_die_en | input | 8 | Per-pin digital-input override enable |
| ovr_die_val | input | 8 | Per-pin digital-input override value |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output level |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
The assertions assume that `spi_en`, `spi_master`, `pull_dis` and the override vectors come from logic synchronous to `clk`, so they are stable at every rising edge. They also assume the bus write strobe and address are clean at that edge. The bench changes all of these inputs only on falling edges. It holds the pull-up override enables at 0 wherever it checks the pull-up rules that the assertions cover.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    typedef enum logic [1:0] {
        ADDR_DIR = 2'd0,
        ADDR_OUT = 2'd1,
        ADDR_PIN = 2'd2,
        ADDR_RSV = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic oe;
        logic lvl;
        logic pu;
        logic die;
    } pin_ctl_t;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);
    import gpio_ovr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] out;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (reg_addr_e'(bus_addr))
                ADDR_DIR: regs_d.dir = bus_wdata;
                ADDR_OUT: regs_d.out = bus_wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dir_q = regs_q.dir;
    assign out_q = regs_q.out;

    // R2: a direction write is visible one edge later
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> (dir_q == $past(bus_wdata)));

    // R10: writes to the pin or reserved address leave both registers alone
    a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[1]) |=> ($stable(dir_q) && $stable(out_q)));

endmodule

// File: rtl/gpio_spi_ovr.sv
module gpio_spi_ovr #(
    parameter int WIDTH    = 8,
    parameter int SCK_BIT  = 7,
    parameter int MISO_BIT = 6
) (
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic [WIDTH-1:0] ext_dir_en,
    input  logic [WIDTH-1:0] ext_dir_val,
    output logic [WIDTH-1:0] dir_en_eff,
    output logic [WIDTH-1:0] dir_val_eff
);
    logic force_sck_in;
    logic force_miso_in;

    assign force_sck_in  = spi_en && !spi_master;
    assign force_miso_in = spi_en &&  spi_master;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == SCK_BIT) begin : g_sck
            assign dir_en_eff[i]  = force_sck_in | ext_dir_en[i];
            assign dir_val_eff[i] = force_sck_in ? 1'b0 : ext_dir_val[i];
        end else if (i == MISO_BIT) begin : g_miso
            assign dir_en_eff[i]  = force_miso_in | ext_dir_en[i];
            assign dir_val_eff[i] = force_miso_in ? 1'b0 : ext_dir_val[i];
        end else begin : g_plain
            assign dir_en_eff[i]  = ext_dir_en[i];
            assign dir_val_eff[i] = ext_dir_val[i];
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    input  logic             pull_dis,
    input  logic [WIDTH-1:0] pu_en,
    input  logic [WIDTH-1:0] pu_val,
    input  logic [WIDTH-1:0] dir_en,
    input  logic [WIDTH-1:0] dir_val,
    input  logic [WIDTH-1:0] lvl_en,
    input  logic [WIDTH-1:0] lvl_val,
    input  logic [WIDTH-1:0] die_en,
    input  logic [WIDTH-1:0] die_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] dig_in_en
);
    import gpio_ovr_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_ctl_t ctl;
        always_comb begin
            ctl.oe  = dir_en[i] ? dir_val[i] : dir_q[i];
            ctl.lvl = lvl_en[i] ? lvl_val[i] : out_q[i];
            ctl.pu  = pu_en[i]  ? pu_val[i]
                                : (!ctl.oe && out_q[i] && !pull_dis);
            ctl.die = die_en[i] ? die_val[i] : 1'b1;
        end
        assign pad_oe[i]    = ctl.oe;
        assign pad_out[i]   = ctl.lvl;
        assign pad_pu[i]    = ctl.pu;
        assign dig_in_en[i] = ctl.die;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] dig_in_en,
    output logic [WIDTH-1:0] pin_q
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] pin;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = pad_in & dig_in_en;
        sync_d.pin  = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_q = sync_q.pin;

    // R9: a pin whose input gate was closed two edges ago reads 0
    a_r9_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sync_q.meta & ~$past(dig_in_en)) == '0));

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
    parameter int WIDTH    = 8,
    parameter int SCK_BIT  = 7,
    parameter int MISO_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             pull_dis,
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic [WIDTH-1:0] ovr_pu_en,
    input  logic [WIDTH-1:0] ovr_pu_val,
    input  logic [WIDTH-1:0] ovr_dir_en,
    input  logic [WIDTH-1:0] ovr_dir_val,
    input  logic [WIDTH-1:0] ovr_out_en,
    input  logic [WIDTH-1:0] ovr_out_val,
    input  logic [WIDTH-1:0] ovr_die_en,
    input  logic [WIDTH-1:0] ovr_die_val,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    import gpio_ovr_pkg::*;

    logic [WIDTH-1:0] dir_q, out_q, pin_q;
    logic [WIDTH-1:0] dir_en_eff, dir_val_eff, dig_in_en;

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q)
    );

    gpio_spi_ovr #(.WIDTH(WIDTH), .SCK_BIT(SCK_BIT), .MISO_BIT(MISO_BIT)) i_spi (
        .spi_en(spi_en), .spi_master(spi_master),
        .ext_dir_en(ovr_dir_en), .ext_dir_val(ovr_dir_val),
        .dir_en_eff(dir_en_eff), .dir_val_eff(dir_val_eff)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) i_mux (
        .dir_q(dir_q), .out_q(out_q), .pull_dis(pull_dis),
        .pu_en(ovr_pu_en), .pu_val(ovr_pu_val),
        .dir_en(dir_en_eff), .dir_val(dir_val_eff),
        .lvl_en(ovr_out_en), .lvl_val(ovr_out_val),
        .die_en(ovr_die_en), .die_val(ovr_die_val),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .dig_in_en(dig_in_en)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) i_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .dig_in_en(dig_in_en), .pin_q(pin_q)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            ADDR_DIR: bus_rdata = dir_q;
            ADDR_OUT: bus_rdata = out_q;
            ADDR_PIN: bus_rdata = pin_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R4: slave role keeps the clock pin undriven
    a_r4_sck_slave_in: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> !pad_oe[SCK_BIT]);

    // R6: master role keeps the data-in pin undriven
    a_r6_miso_master_in: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> !pad_oe[MISO_BIT]);

    // R8: no register-derived pull-up on a driven pin
    a_r8_no_pu_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe & ~ovr_pu_en) == '0));

    // R8: global disable clears all register-derived pull-ups
    a_r8_pull_dis: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> ((pad_pu & ~ovr_pu_en) == '0));

    // R10: reserved address reads zero
    a_r10_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic pull_dis = 1'b0, spi_en = 1'b0, spi_master = 1'b0;
    logic [W-1:0] ovr_pu_en = '0, ovr_pu_val = '0, ovr_dir_en = '0, ovr_dir_val = '0;
    logic [W-1:0] ovr_out_en = '0, ovr_out_val = '0, ovr_die_en = '0, ovr_die_val = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ovr_port i_gpio_ovr_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_dis(pull_dis),
        .spi_en(spi_en), .spi_master(spi_master),
        .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
        .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
        .ovr_out_en(ovr_out_en), .ovr_out_val(ovr_out_val),
        .ovr_die_en(ovr_die_en), .ovr_die_val(ovr_die_val),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // {spi_en, master, dir bit, out bit, sck_oe, sck_pu, miso_oe, miso_pu}
    localparam logic [7:0] VEC [16] = '{
        8'b0000_0000, 8'b0001_0101, 8'b0010_1010, 8'b0011_1010,
        8'b0100_0000, 8'b0101_0101, 8'b0110_1010, 8'b0111_1010,
        8'b1000_0000, 8'b1001_0101, 8'b1010_0010, 8'b1011_0110,
        8'b1100_0000, 8'b1101_0101, 8'b1110_1000, 8'b1111_1001
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_pu", pad_pu, '0);
        rd(2'd0, r); check("R1 dir", r, '0);

        // R4 R5 R6 R7 table of SPI role cases on clock and data-in pins
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = VEC[k];
            wr(2'd0, v[5] ? 8'hC0 : 8'h00);
            wr(2'd1, v[4] ? 8'hC0 : 8'h00);
            spi_en = v[7]; spi_master = v[6];
            #1;
            check($sformatf("R4/R5 sck_oe vec%0d", k), W'(pad_oe[7]), W'(v[3]));
            check($sformatf("R7 sck_pu vec%0d", k), W'(pad_pu[7]), W'(v[2]));
            check($sformatf("R6 miso_oe vec%0d", k), W'(pad_oe[6]), W'(v[1]));
            check($sformatf("R7 miso_pu vec%0d", k), W'(pad_pu[6]), W'(v[0]));
        end

        // R4 SPI slave wins over external direction override on clock pin
        wr(2'd0, 8'h80);
        spi_en = 1'b1; spi_master = 1'b0;
        ovr_dir_en = 8'h80; ovr_dir_val = 8'h80;
        #1 check("R4 over ext override", W'(pad_oe[7]), 8'h00);
        spi_en = 1'b0; ovr_dir_en = '0; ovr_dir_val = '0;

        // R2 writes and readback
        wr(2'd0, 8'h3C);
        rd(2'd0, r); check("R2 dir readback", r, 8'h3C);
        wr(2'd1, 8'h5A);
        rd(2'd1, r); check("R2 out readback", r, 8'h5A);
        check("R2 pad_out", pad_out, 8'h5A);
        check("R2 pad_oe", pad_oe, 8'h3C);

        // R8 pull-up rule: input and out bit 1
        check("R8 pad_pu", pad_pu, (~8'h3C) & 8'h5A);
        @(negedge clk); pull_dis = 1'b1;
        #1 check("R8 pull_dis", pad_pu, 8'h00);
        pull_dis = 1'b0;

        // R3 overrides
        ovr_out_en = 8'h01; ovr_out_val = 8'h01;
        ovr_dir_en = 8'h02; ovr_dir_val = 8'h02;
        ovr_pu_en  = 8'h04; ovr_pu_val  = 8'h04;
        #1;
        check("R3 level override", pad_out, 8'h5B);
        check("R3 dir override", pad_oe, 8'h3E);
        check("R3 pu override", pad_pu, 8'h42 & 8'h40 | 8'h04 | 8'h40);
        ovr_out_en = '0; ovr_dir_en = '0; ovr_pu_en = '0;
        ovr_out_val = '0; ovr_dir_val = '0; ovr_pu_val = '0;

        // R10 writes to pin and reserved addresses ignored
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd0, r); check("R10 dir kept", r, 8'h3C);
        rd(2'd1, r); check("R10 out kept", r, 8'h5A);
        rd(2'd3, r); check("R10 rsv zero", r, 8'h00);

        // R9 synchroniser latency and input gating (R3 die override)
        @(negedge clk);
        pad_in = 8'hA5; bus_addr = 2'd2;
        @(negedge clk);
        rd(2'd2, r); check("R9 one edge", r, 8'h00);
        @(negedge clk);
        rd(2'd2, r); check("R9 two edges", r, 8'hA5);
        ovr_die_en = 8'h01; ovr_die_val = 8'h00;
        repeat (2) @(negedge clk);
        rd(2'd2, r); check("R9 R3 die gated", r, 8'hA4);
        ovr_die_en = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule